// File: doc/BRIEF.md
# Dual-Clause Station Management Master

This block is the master side of a serial PHY management bus. It produces a management clock and a single bidirectional data line, and it builds both the older 32-bit short-address frames and the extended indirect-address frames. Software sets up a configuration word, loads a 16-bit payload word and then writes a command word. Writing the command word starts exactly one frame on the wire. Software then polls the pending flags until the frame is over.

The configuration word chooses the frame format, whether the 32-bit preamble of ones is sent, and the divider for the management clock. The command word holds a two-bit operation, the PHY address and a five-bit register field. In extended mode that register field names the device. There, the payload word carries either the register address (address cycles) or the data (write cycles). A read of an extended register therefore takes two frames: an address frame, then a read frame to the same PHY and device.

During reads the master lets go of the data line from the turnaround field onwards. It samples the PHY's bits on the rising clock edge. It keeps the 16 returned bits together with a flag that says whether the PHY answered in the turnaround.

Top module: `mgmt_frame_master`

## Requirements
- R1: Register 0 (config) holds the clock half-period count in bits [DIV_W-1:0], the extended-format select in bit 16 and the preamble enable in bit 17. It reads back as written, and it resets to half-period 4, short format and preamble on (0x20004).
- R2: A write to register 1 (command) starts one frame when no operation is pending. Register 1 has the register/device field in [4:0], the PHY address in [12:8] and the operation in [17:16]. Register 2 bits [15:0] hold the payload.
- R3: A frame, MSB first, is: 32 ones (only when the preamble is enabled), a 2-bit start field, a 2-bit wire opcode, the 5-bit PHY address, the 5-bit register/device field, the turnaround 10 and 16 payload bits.
- R4: In short format the start field is 01. Operation 0 (write) sends opcode 01 and operation 1 (read) sends opcode 10. Operations 2 and 3 are ignored: no frame is sent and no flag changes.
- R5: In extended format the start field is 00. Operations 0 (address), 1 (write), 2 (read with increment) and 3 (read) send opcodes 00, 01, 10 and 11. The register field carries the device number, and the payload register supplies the data bits.
- R6: Register 2 bit 16 (write pending) is set when a write or address command starts, and clears when that frame has finished on the wire.
- R7: For a read, the master releases the data line from the first turnaround bit to the end of the frame. It shifts in the 16 data bits on rising clock edges. Register 3 gives the data in [15:0], valid in bit 16 and pending in bit 17. Pending is set at the start of the read and clears at its end, and valid clears when a read starts.
- R8: Valid is set at the end of a read only if the PHY drove 0 in the second turnaround bit.
- R9: The management clock has a high and low time of (half-period count + 1) system clocks. It stays low and the data line stays released while no frame runs. The master changes its data output only on falling clock edges.
- R10: A command written while a write or a read is pending is ignored. The running frame completes unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register index for writes |
| reg_wr_data | input | 18 | Register write data |
| reg_rd_addr | input | 2 | Register index for reads |
| reg_rd_data | output | 18 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The embedded assertions watch every cycle for four things. The management clock must be low and the data line released whenever no frame runs. The master's output and enable may change only on falling clock edges. A pending flag may drop only in the cycle after a frame ends, and the valid flag may rise only after a frame whose turnaround was answered. A frame may start only when the engine is idle. The bench's PHY model is needed for the rest: it captures the driven bits to prove the field order and opcode mapping for each format. It returns data and a good or bad turnaround, measures the clock period against the divider, and shows that illegal short-format operations and commands issued during a busy frame leave the wire quiet.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    localparam int FRAME_BITS   = 32;
    localparam int PRE_BITS     = 32;
    localparam int DATA_BITS    = 16;
    localparam int ADDR_BITS    = 5;
    localparam int RELEASE_POS  = 14;
    localparam int TA2_POS      = 15;
    localparam int REG_W        = 18;
    localparam int MODE_BIT     = 16;
    localparam int PRE_BIT      = 17;
    localparam int RVALID_BIT   = 16;
    localparam int RPEND_BIT    = 17;
    localparam int WPEND_BIT    = 16;
    localparam int OP_LSB       = 16;
    localparam int PHY_LSB      = 8;
    localparam int REGF_LSB     = 0;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_WDAT = 2'd2,
        SEL_RDAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d   = st_q;
        wrap   = run_i && (st_q.cnt == half_i);
        rise_o = wrap && !st_q.mdc;
        fall_o = wrap && st_q.mdc;
        if (!run_i) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o = st_q.mdc;

    // R9
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);
endmodule

// File: rtl/mgmt_frame_eng.sv
module mgmt_frame_eng
    import mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  read_i,
    input  logic                  pre_en_i,
    input  logic                  rise_i,
    input  logic                  fall_i,
    input  logic                  mdio_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  mdio_o,
    output logic                  mdio_oe_o,
    output logic [DATA_BITS-1:0]  rdata_o,
    output logic                  ta_ok_o
);
    localparam int PW = $clog2(PRE_BITS + 1);
    localparam int FW = $clog2(FRAME_BITS);
    localparam logic [FW-1:0] LAST_POS = FW'(FRAME_BITS - 1);
    localparam logic [FW-1:0] REL_POS  = FW'(RELEASE_POS);
    localparam logic [FW-1:0] TA2      = FW'(TA2_POS);

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [PW-1:0]         pre_left;
        logic [FW-1:0]         pos;
        logic [FRAME_BITS-1:0] sh;
        logic [DATA_BITS-1:0]  rdat;
        logic                  ta_ok;
    } eng_t;

    eng_t st_d, st_q;
    logic in_frame;

    always_comb begin
        st_d     = st_q;
        in_frame = (st_q.pre_left == '0);
        done_o   = st_q.busy && fall_i && in_frame && (st_q.pos == LAST_POS);
        if (start_i && !st_q.busy) begin
            st_d.busy     = 1'b1;
            st_d.rd       = read_i;
            st_d.pre_left = pre_en_i ? PW'(PRE_BITS) : '0;
            st_d.pos      = '0;
            st_d.sh       = frame_i;
            st_d.ta_ok    = 1'b0;
        end else if (st_q.busy) begin
            if (rise_i && in_frame && st_q.rd) begin
                if (st_q.pos == TA2)
                    st_d.ta_ok = !mdio_i;
                else if (st_q.pos > TA2)
                    st_d.rdat = {st_q.rdat[DATA_BITS-2:0], mdio_i};
            end
            if (fall_i) begin
                if (!in_frame) begin
                    st_d.pre_left = st_q.pre_left - 1'b1;
                end else if (st_q.pos == LAST_POS) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                    st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign mdio_o    = (st_q.pre_left != '0) ? 1'b1 : st_q.sh[FRAME_BITS-1];
    assign mdio_oe_o = st_q.busy &&
                       !(st_q.rd && (st_q.pre_left == '0) && (st_q.pos >= REL_POS));
    assign rdata_o   = st_q.rdat;
    assign ta_ok_o   = st_q.ta_ok;

    // R9
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fall_i) |=> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
    import mgmt_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_wr_addr,
    input  logic [REG_W-1:0] reg_wr_data,
    input  logic [1:0]       reg_rd_addr,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    typedef struct packed {
        logic [DIV_W-1:0]     half;
        logic                 ext;
        logic                 pre_en;
        logic [DATA_BITS-1:0] wdat;
        logic                 wpend;
        logic                 rpend;
        logic                 rvalid;
        logic [DATA_BITS-1:0] rdat;
    } regs_t;

    regs_t rg_d, rg_q;

    logic                  eng_start, eng_busy, eng_done, eng_ta_ok, eng_read;
    logic                  mdc_rise, mdc_fall;
    logic [FRAME_BITS-1:0] eng_frame;
    logic [DATA_BITS-1:0]  eng_rdata;
    logic [1:0]            cmd_op, wire_op, start_fld;
    logic [ADDR_BITS-1:0]  cmd_phy, cmd_reg;
    logic                  cmd_legal;

    always_comb begin
        rg_d      = rg_q;
        cmd_op    = reg_wr_data[OP_LSB +: 2];
        cmd_phy   = reg_wr_data[PHY_LSB +: ADDR_BITS];
        cmd_reg   = reg_wr_data[REGF_LSB +: ADDR_BITS];
        cmd_legal = rg_q.ext || !cmd_op[1];
        eng_read  = rg_q.ext ? cmd_op[1] : cmd_op[0];
        wire_op   = rg_q.ext ? cmd_op : (cmd_op[0] ? 2'b10 : 2'b01);
        start_fld = rg_q.ext ? 2'b00 : 2'b01;
        eng_frame = {start_fld, wire_op, cmd_phy, cmd_reg,
                     eng_read ? 2'b11 : 2'b10,
                     eng_read ? {DATA_BITS{1'b0}} : rg_q.wdat};
        eng_start = reg_wr_en && (reg_wr_addr == SEL_CMD) &&
                    !rg_q.wpend && !rg_q.rpend && cmd_legal;

        if (reg_wr_en && reg_wr_addr == SEL_CFG) begin
            rg_d.half   = reg_wr_data[DIV_W-1:0];
            rg_d.ext    = reg_wr_data[MODE_BIT];
            rg_d.pre_en = reg_wr_data[PRE_BIT];
        end
        if (reg_wr_en && reg_wr_addr == SEL_WDAT)
            rg_d.wdat = reg_wr_data[DATA_BITS-1:0];
        if (eng_start) begin
            if (eng_read) begin
                rg_d.rpend  = 1'b1;
                rg_d.rvalid = 1'b0;
            end else begin
                rg_d.wpend  = 1'b1;
            end
        end
        if (eng_done) begin
            rg_d.wpend = 1'b0;
            rg_d.rpend = 1'b0;
            if (rg_q.rpend) begin
                rg_d.rdat   = eng_rdata;
                rg_d.rvalid = eng_ta_ok;
            end
        end

        reg_rd_data = '0;
        unique case (reg_rd_addr)
            SEL_CFG: begin
                reg_rd_data[DIV_W-1:0] = rg_q.half;
                reg_rd_data[MODE_BIT]  = rg_q.ext;
                reg_rd_data[PRE_BIT]   = rg_q.pre_en;
            end
            SEL_CMD: reg_rd_data = '0;
            SEL_WDAT: begin
                reg_rd_data[DATA_BITS-1:0] = rg_q.wdat;
                reg_rd_data[WPEND_BIT]     = rg_q.wpend;
            end
            default: begin
                reg_rd_data[DATA_BITS-1:0] = rg_q.rdat;
                reg_rd_data[RVALID_BIT]    = rg_q.rvalid;
                reg_rd_data[RPEND_BIT]     = rg_q.rpend;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q        <= '0;
            rg_q.half   <= DIV_W'(DIV_RESET);
            rg_q.pre_en <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    mgmt_mdc_gen #(.DIV_W(DIV_W)) clkgen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (eng_busy),
        .half_i (rg_q.half),
        .mdc_o  (mdc),
        .rise_o (mdc_rise),
        .fall_o (mdc_fall)
    );

    mgmt_frame_eng engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (eng_start),
        .frame_i   (eng_frame),
        .read_i    (eng_read),
        .pre_en_i  (rg_q.pre_en),
        .rise_i    (mdc_rise),
        .fall_i    (mdc_fall),
        .mdio_i    (mdio_i),
        .busy_o    (eng_busy),
        .done_o    (eng_done),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .rdata_o   (eng_rdata),
        .ta_ok_o   (eng_ta_ok)
    );

    // R10
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);

    // R6 R7
    pend_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rg_q.wpend) || $fell(rg_q.rpend)) |-> $past(eng_done));

    // R8
    valid_needs_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rg_q.rvalid) |-> $past(eng_done && eng_ta_ok));

    // R9
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (!mdio_oe && !mdc));
endmodule

// File: tb/mgmt_frame_master_tb.sv
module mgmt_frame_master_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        ext;
        logic        pre;
        logic [7:0]  div;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] wd;
        logic [15:0] resp;
        logic        tabad;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'd1, 2'd0, 5'h03, 5'h00, 16'h1340, 16'h0000, 1'b0},
        '{1'b0, 1'b1, 8'd2, 2'd1, 5'h1F, 5'h02, 16'h0000, 16'hA55A, 1'b0},
        '{1'b1, 1'b0, 8'd0, 2'd0, 5'h01, 5'h1E, 16'h8001, 16'h0000, 1'b0},
        '{1'b1, 1'b1, 8'd3, 2'd1, 5'h01, 5'h1E, 16'h0F0F, 16'h0000, 1'b0},
        '{1'b1, 1'b0, 8'd1, 2'd3, 5'h10, 5'h03, 16'h0000, 16'h8421, 1'b0},
        '{1'b1, 1'b1, 8'd1, 2'd2, 5'h0A, 5'h07, 16'h0000, 16'hFFFE, 1'b0},
        '{1'b0, 1'b0, 8'd1, 2'd1, 5'h02, 5'h01, 16'h0000, 16'h1234, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = '0;
    logic [17:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_addr = '0;
    logic [17:0] reg_rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    // bench PHY model state
    logic [63:0] cap = '0;
    int          ncap = 0;
    int          edge_cnt = 0;
    int          pre_len = 0;
    logic [15:0] phy_resp = '0;
    logic        phy_ta = 1'b0;
    longint      last_rise = 0;
    longint      period = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_frame_master dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        #1;
        if (mdio_oe) begin
            cap  = {cap[62:0], mdio_o};
            ncap = ncap + 1;
        end
        period    = $time - last_rise;
        last_rise = $time;
        edge_cnt  = edge_cnt + 1;
        begin
            int nxt;
            nxt = edge_cnt - pre_len;
            if (nxt == 15)                 mdio_i = phy_ta;
            else if (nxt >= 16 && nxt <= 31) mdio_i = phy_resp[31 - nxt];
            else                           mdio_i = 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [17:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [17:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    task automatic phy_arm(input int pl, input logic [15:0] resp, input logic ta);
        cap = '0; ncap = 0; edge_cnt = 0; pre_len = pl;
        phy_resp = resp; phy_ta = ta; mdio_i = 1'b1;
    endtask

    task automatic wait_idle();
        logic [17:0] w, r;
        for (int i = 0; i < 4000; i++) begin
            reg_rd(2'd2, w);
            reg_rd(2'd3, r);
            if (!w[16] && !r[17]) break;
        end
    endtask

    function automatic logic [17:0] mk_cmd(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] ra);
        logic [17:0] c;
        c = '0; c[17:16] = op; c[12:8] = phy; c[4:0] = ra;
        return c;
    endfunction

    // expected frame from R3/R4/R5
    function automatic logic [31:0] exp_frame(input vec_t v);
        logic [1:0] st, wop;
        st  = v.ext ? 2'b00 : 2'b01;
        wop = v.ext ? v.op : (v.op == 2'd0 ? 2'b01 : 2'b10);
        return {st, wop, v.phy, v.ra, 2'b10, v.wd};
    endfunction

    task automatic run_vec(input vec_t v);
        logic [17:0] r;
        logic [31:0] ef;
        logic [63:0] pre_part;
        bit          rd;
        int          nexp;
        rd = v.ext ? v.op[1] : v.op[0];
        ef = exp_frame(v);
        reg_wr(2'd0, {v.pre, v.ext, 8'h00, v.div});
        reg_wr(2'd2, {2'b00, v.wd});
        phy_arm(v.pre ? 32 : 0, v.resp, v.tabad);
        reg_wr(2'd1, mk_cmd(v.op, v.phy, v.ra));
        if (rd) begin
            reg_rd(2'd3, r);
            check(r[17] == 1'b1 && r[16] == 1'b0, "R7 read pending set, valid cleared", r[17:16], 2'b10);
        end else begin
            reg_rd(2'd2, r);
            check(r[16] == 1'b1, "R6 write pending set", r[16], 1);
        end
        wait_idle();
        nexp = (v.pre ? 32 : 0) + (rd ? 14 : 32);
        check(ncap == nexp, "R3 driven bit count", ncap, nexp);
        if (rd) check(cap[13:0] == ef[31:18], v.ext ? "R5 read header" : "R4 read header",
                      cap[13:0], ef[31:18]);
        else    check(cap[31:0] == ef, v.ext ? "R5 frame bits" : "R4 frame bits", cap[31:0], ef);
        if (v.pre) begin
            pre_part = cap >> (rd ? 14 : 32);
            check(pre_part[31:0] == 32'hFFFF_FFFF, "R3 preamble ones", pre_part[31:0], 32'hFFFF_FFFF);
        end
        check(period == longint'(2 * (v.div + 1) * CLK_PERIOD), "R9 mdc period",
              period, 2 * (v.div + 1) * CLK_PERIOD);
        if (rd) begin
            reg_rd(2'd3, r);
            if (v.tabad)
                check(r[16] == 1'b0 && r[17] == 1'b0, "R8 valid stays low on bad turnaround",
                      r[17:16], 2'b00);
            else
                check(r[17:0] == {2'b01, v.resp}, "R7 read data and valid", r, {2'b01, v.resp});
        end else begin
            reg_rd(2'd2, r);
            check(r[16] == 1'b0, "R6 write pending cleared", r[16], 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [17:0] r;
        int          hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_rd(2'd0, r);
        check(r == 18'h20004, "R1 config reset", r, 18'h20004);
        reg_rd(2'd2, r);
        check(r[16] == 1'b0, "R6 write pending at reset", r[16], 0);
        reg_rd(2'd3, r);
        check(r == 18'h0, "R7 read register at reset", r, 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle bus at reset", {mdc, mdio_oe}, 0);

        reg_wr(2'd0, 18'h10007);
        reg_rd(2'd0, r);
        check(r == 18'h10007, "R1 config readback", r, 18'h10007);

        // vector table
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R4: illegal short-format operations ignored
        reg_wr(2'd0, 18'h20001);
        phy_arm(32, 16'h0, 1'b0);
        reg_wr(2'd1, mk_cmd(2'd2, 5'h04, 5'h04));
        reg_wr(2'd1, mk_cmd(2'd3, 5'h04, 5'h04));
        reg_rd(2'd2, r);
        check(r[16] == 1'b0, "R4 illegal op sets no write pending", r[16], 0);
        reg_rd(2'd3, r);
        check(r[17] == 1'b0, "R4 illegal op sets no read pending", r[17], 0);
        repeat (100) @(negedge clk);
        check(edge_cnt == 0 && ncap == 0, "R4 illegal op leaves wire quiet", edge_cnt, 0);

        // R10: command while busy ignored
        reg_wr(2'd2, 18'h0BEEF);
        phy_arm(32, 16'h0, 1'b0);
        reg_wr(2'd1, mk_cmd(2'd0, 5'h06, 5'h09));
        repeat (20) @(negedge clk);
        reg_wr(2'd1, mk_cmd(2'd1, 5'h11, 5'h11));
        reg_rd(2'd3, r);
        check(r[17] == 1'b0, "R10 second command sets no read pending", r[17], 0);
        wait_idle();
        check(ncap == 64, "R10 single frame bit count", ncap, 64);
        check(cap[31:0] == {2'b01, 2'b01, 5'h06, 5'h09, 2'b10, 16'hBEEF},
              "R10 first frame unchanged", cap[31:0], {2'b01, 2'b01, 5'h06, 5'h09, 2'b10, 16'hBEEF});
        hold = edge_cnt;
        repeat (300) @(negedge clk);
        check(edge_cnt == hold && mdc == 1'b0 && mdio_oe == 1'b0,
              "R10 R9 no frame follows, bus idle", edge_cnt, hold);

        // R2: after idle a new command is accepted again
        reg_wr(2'd1, mk_cmd(2'd0, 5'h06, 5'h09));
        reg_rd(2'd2, r);
        check(r[16] == 1'b1, "R2 command accepted when idle", r[16], 1);
        wait_idle();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule